// File: doc/BRIEF.md
# Processor Bus Target Response Controller

This block sits on the target side of a host bridge attached to a processor bus with separate address and data tenures. It samples a transfer start and holds the type code, address, burst flag, size and write data in a capture stage. It sorts the transfer into one of three classes: address-only, write or read. A set of address windows, each with a base, a power-of-two size and a posting attribute, decides whether the bridge claims the transfer. The block then drives the address acknowledge, transfer acknowledge and retry outputs.

A posted write is stored in a small internal write queue and acknowledged at once. A burst write is always posted, because a retry is only legal up to the first data acknowledge. A compelled transfer is a read, or a single-beat write in a non-posted window. For these the block raises a request to a downstream stub and waits. A success from the stub becomes an acknowledge, and a failure becomes a retry. When the queue is full, the address acknowledge itself is withheld. The queue is drained through a simple valid/pop port.

Top module: `slv_resp_ctrl`

## Requirements
- R1: Type codes are classified as follows. Address-only: 5'b00000, 5'b00100, 5'b01000, 5'b01100, 5'b10000. Write: 5'b00010, 5'b00110. Read: 5'b01010, 5'b01110. Every other code is unclaimed.
- R2: An address-only transfer that hits a window gets a one-cycle `aack` in the cycle after its start is sampled, with no `tack` and no `retry`. One that misses every window gets no response. After reset all response outputs, `dn_req` and `wq_valid` are low.
- R3: An unclaimed type code gives no `aack`, `tack`, `retry`, `dn_req` or queue push. So does a read or write that misses every window.
- R4: A posted write is one that hits window 0 (base 0x8000_0000, 16 MiB, posting on), or any burst write that hits a window. When the queue has room, a posted write gets `aack` and its first `tack` in the cycle after the start is sampled, and it is pushed into the queue in that same cycle.
- R5: A burst write that hits window 1 (base 0xC000_0000, 64 KiB, posting off) is still posted and never raises `dn_req`.
- R6: While the queue holds WQ_DEPTH entries, a posted write gets no `aack`. It is acknowledged two cycles after the pop that frees an entry. The queue never holds more than WQ_DEPTH entries.
- R7: A compelled transfer raises `dn_req` in the cycle after its start is sampled. `dn_req` stays high until `dn_done` or `dn_fail`, and no `aack` is given while it is high.
- R8: `dn_done` gives `aack` with `tack` in the next cycle. `dn_fail` gives `aack` with `retry` and no `tack` in the next cycle.
- R9: `retry` only appears together with `aack`, and never after a `tack` of the same tenure.
- R10: A burst gives BEATS consecutive `tack` cycles, starting with the `aack` cycle. A single-beat transfer gives exactly one.
- R11: The queue hands out entries in push order, with the address, burst flag and data as captured. Popping a valid head removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Transfer start, one cycle |
| ts_type | input | 5 | Transfer type code |
| ts_addr | input | AW | Transfer address |
| ts_burst | input | 1 | Burst (BEATS beats) transfer |
| ts_size | input | 3 | Transfer size code, stored with writes |
| ts_wdata | input | BEATS*DW | Write data for all beats |
| aack | output | 1 | Address acknowledge |
| tack | output | 1 | Transfer (data beat) acknowledge |
| retry | output | 1 | Retry, qualified with aack |
| dn_req | output | 1 | Compelled request to downstream stub |
| dn_addr | output | AW | Address of compelled request |
| dn_write | output | 1 | Compelled request is a write |
| dn_burst | output | 1 | Compelled request is a burst |
| dn_done | input | 1 | Downstream success pulse |
| dn_fail | input | 1 | Downstream failure pulse |
| wq_pop | input | 1 | Remove queue head |
| wq_valid | output | 1 | Queue head valid |
| wq_addr | output | AW | Head address |
| wq_size | output | 3 | Head size code |
| wq_burst | output | 1 | Head burst flag |
| wq_data | output | BEATS*DW | Head data beats |

## Verification
The case of interest is a pop of the write queue that lands in the same cycle as a full-queue check of a waiting posted write. The bench fills the queue with bursts while draining is off, and then starts a fifth posted write. It issues a single pop while that write is stalled and requires the `aack` exactly two samples after the pop, with no `aack` before. Random traffic with random draining also makes pushes and pops coincide. A model queue of the bench checks every popped head against the expected order, and checks that its occupancy never goes past the depth.

// File: rtl/slv_pkg.sv
`timescale 1ns/1ps
package slv_pkg;

  typedef enum logic [1:0] {
    TC_NONE  = 2'd0,
    TC_AONLY = 2'd1,
    TC_WRITE = 2'd2,
    TC_READ  = 2'd3
  } tclass_e;

  // Sort a transfer type code into its response class.
  function automatic tclass_e classify_tt(input logic [4:0] tt);
    tclass_e c;
    case (tt)
      5'b00000, 5'b00100, 5'b01000, 5'b01100, 5'b10000: c = TC_AONLY;
      5'b00010, 5'b00110:                               c = TC_WRITE;
      5'b01010, 5'b01110:                               c = TC_READ;
      default:                                          c = TC_NONE;
    endcase
    return c;
  endfunction

  // Address falls inside a naturally aligned window of 2**lg bytes.
  function automatic logic win_match(input logic [63:0] a,
                                     input logic [63:0] base,
                                     input logic [5:0]  lg);
    logic [63:0] keep;
    keep = ~((64'd1 << lg) - 64'd1);
    return ((a ^ base) & keep) == 64'd0;
  endfunction

endpackage

// File: rtl/slv_decode.sv
`timescale 1ns/1ps
module slv_decode #(
  parameter int unsigned AW      = 32,
  parameter int unsigned NUM_WIN = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASE = '0,
  parameter logic [NUM_WIN*6-1:0]  WIN_LG   = '0,
  parameter logic [NUM_WIN-1:0]    WIN_POST = '0
) (
  input  logic [4:0]       tt,
  input  logic [AW-1:0]    addr,
  input  logic             burst,
  output slv_pkg::tclass_e cls,
  output logic             hit,
  output logic             posted
);
  logic [NUM_WIN-1:0] hv;
  logic               attr;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hv[w] = slv_pkg::win_match(64'(addr), 64'(WIN_BASE[w*AW +: AW]),
                                      WIN_LG[w*6 +: 6]);
  end

  // Lowest-numbered matching window supplies the posting attribute.
  always_comb begin
    attr = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hv[w]) attr = WIN_POST[w];
    end
  end

  assign cls    = slv_pkg::classify_tt(tt);
  assign hit    = |hv;
  assign posted = (cls == slv_pkg::TC_WRITE) && (burst || attr);
endmodule

// File: rtl/slv_wq.sv
`timescale 1ns/1ps
module slv_wq #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [W-1:0]         din,
  input  logic                 pop,
  output logic                 valid,
  output logic [W-1:0]         dout,
  output logic                 full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  assign do_push = push && (cnt != CNT_MAX);
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= bump(wr_p);
      if (do_pop)  rd_p <= bump(rd_p);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign valid = (cnt != '0);
  assign dout  = mem[rd_p];
  assign full  = (cnt == CNT_MAX);
  assign count = cnt;
endmodule

// File: rtl/slv_resp_fsm.sv
`timescale 1ns/1ps
module slv_resp_fsm #(
  parameter int unsigned BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_valid,
  input  slv_pkg::tclass_e cls,
  input  logic             hit,
  input  logic             posted,
  input  logic             burst,
  input  logic             wq_full,
  input  logic             dn_done,
  input  logic             dn_fail,
  output logic             idle,
  output logic             aack,
  output logic             tack,
  output logic             retry,
  output logic             dn_req,
  output logic             push
);
  localparam int unsigned BCW = $clog2(BEATS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_WFULL, S_WAITDN, S_BEATS
  } st_e;

  st_e            st;
  logic [BCW-1:0] left;
  logic           is_rw, post_go;

  assign is_rw   = (cls == slv_pkg::TC_WRITE) || (cls == slv_pkg::TC_READ);
  assign post_go = !wq_full &&
                   (((st == S_DEC) && is_rw && hit && posted) || (st == S_WFULL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      left   <= '0;
      aack   <= 1'b0;
      tack   <= 1'b0;
      retry  <= 1'b0;
      dn_req <= 1'b0;
      push   <= 1'b0;
    end else begin
      aack  <= 1'b0;
      tack  <= 1'b0;
      retry <= 1'b0;
      push  <= 1'b0;
      if (post_go) begin
        aack <= 1'b1;
        tack <= 1'b1;
        push <= 1'b1;
        left <= BCW'(BEATS - 1);
        st   <= burst ? S_BEATS : S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (ts_valid) st <= S_DEC;
          S_DEC: begin
            st <= S_IDLE;
            if (cls == slv_pkg::TC_AONLY) begin
              aack <= hit;
            end else if (is_rw && hit) begin
              if (posted) st <= S_WFULL;
              else begin
                dn_req <= 1'b1;
                st     <= S_WAITDN;
              end
            end
          end
          S_WFULL: st <= S_WFULL;
          S_WAITDN: begin
            if (dn_fail) begin
              aack   <= 1'b1;
              retry  <= 1'b1;
              dn_req <= 1'b0;
              st     <= S_IDLE;
            end else if (dn_done) begin
              aack   <= 1'b1;
              tack   <= 1'b1;
              dn_req <= 1'b0;
              left   <= BCW'(BEATS - 1);
              st     <= burst ? S_BEATS : S_IDLE;
            end
          end
          S_BEATS: begin
            tack <= 1'b1;
            left <= left - BCW'(1);
            if (left == BCW'(1)) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign idle = (st == S_IDLE);
endmodule

// File: rtl/slv_resp_ctrl.sv
`timescale 1ns/1ps
module slv_resp_ctrl #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned BEATS    = 4,
  parameter int unsigned WQ_DEPTH = 4,
  parameter int unsigned NUM_WIN  = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASE = {32'hC000_0000, 32'h8000_0000},
  parameter logic [NUM_WIN*6-1:0]  WIN_LG   = {6'd16, 6'd24},
  parameter logic [NUM_WIN-1:0]    WIN_POST = 2'b01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ts_valid,
  input  logic [4:0]          ts_type,
  input  logic [AW-1:0]       ts_addr,
  input  logic                ts_burst,
  input  logic [2:0]          ts_size,
  input  logic [BEATS*DW-1:0] ts_wdata,
  output logic                aack,
  output logic                tack,
  output logic                retry,
  output logic                dn_req,
  output logic [AW-1:0]       dn_addr,
  output logic                dn_write,
  output logic                dn_burst,
  input  logic                dn_done,
  input  logic                dn_fail,
  input  logic                wq_pop,
  output logic                wq_valid,
  output logic [AW-1:0]       wq_addr,
  output logic [2:0]          wq_size,
  output logic                wq_burst,
  output logic [BEATS*DW-1:0] wq_data
);
  localparam int unsigned DATA_W = BEATS * DW;
  localparam int unsigned ENT_W  = AW + 3 + 1 + DATA_W;
  localparam int unsigned CW     = $clog2(WQ_DEPTH + 1);

  logic [4:0]        cap_type;
  logic [AW-1:0]     cap_addr;
  logic              cap_burst;
  logic [2:0]        cap_size;
  logic [DATA_W-1:0] cap_wdata;

  slv_pkg::tclass_e  cls;
  logic              hit, posted, fsm_idle, cap_en;
  logic [ENT_W-1:0]  ent_in, ent_out;

  // Named events for the checker.
  logic              ev_push, ev_pop, wq_full;
  logic [CW-1:0]     wq_count;

  assign cap_en = ts_valid && fsm_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_type  <= '0;
      cap_addr  <= '0;
      cap_burst <= 1'b0;
      cap_size  <= '0;
      cap_wdata <= '0;
    end else if (cap_en) begin
      cap_type  <= ts_type;
      cap_addr  <= ts_addr;
      cap_burst <= ts_burst;
      cap_size  <= ts_size;
      cap_wdata <= ts_wdata;
    end
  end

  slv_decode #(
    .AW(AW), .NUM_WIN(NUM_WIN), .WIN_BASE(WIN_BASE),
    .WIN_LG(WIN_LG), .WIN_POST(WIN_POST)
  ) u_dec (
    .tt(cap_type), .addr(cap_addr), .burst(cap_burst),
    .cls(cls), .hit(hit), .posted(posted)
  );

  slv_resp_fsm #(.BEATS(BEATS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid),
    .cls(cls), .hit(hit), .posted(posted), .burst(cap_burst),
    .wq_full(wq_full), .dn_done(dn_done), .dn_fail(dn_fail),
    .idle(fsm_idle), .aack(aack), .tack(tack), .retry(retry),
    .dn_req(dn_req), .push(ev_push)
  );

  assign ent_in = {cap_addr, cap_size, cap_burst, cap_wdata};

  slv_wq #(.W(ENT_W), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .din(ent_in),
    .pop(wq_pop), .valid(wq_valid), .dout(ent_out),
    .full(wq_full), .count(wq_count)
  );

  assign ev_pop = wq_pop && wq_valid;
  assign {wq_addr, wq_size, wq_burst, wq_data} = ent_out;

  assign dn_addr  = cap_addr;
  assign dn_write = (cls == slv_pkg::TC_WRITE);
  assign dn_burst = cap_burst;
endmodule

// File: rtl/slv_resp_chk.sv
`timescale 1ns/1ps
module slv_resp_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aack,
  input logic          tack,
  input logic          retry,
  input logic          dn_req,
  input logic          ev_push,
  input logic          wq_full,
  input logic [CW-1:0] wq_count
);
  // R9: retry is qualified by the address acknowledge
  a_r9_retry_with_aack: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> aack);

  // R9: no retry right after a data acknowledge
  a_r9_no_late_retry: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !$past(tack));

  // R8: a retried tenure carries no data acknowledge
  a_r8_retry_no_tack: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !tack);

  // R2: address acknowledge lasts one cycle
  a_r2_aack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    aack |=> !aack);

  // R7: nothing acknowledged while the downstream request is open
  a_r7_no_aack_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !aack);

  // R4: a queue push coincides with address and data acknowledge
  a_r4_push_acked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> (aack && tack));

  // R6: no push into a full queue, occupancy bounded
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |-> !wq_full);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wq_count <= CW'(DEPTH));

  // R10: data acknowledges without aack only continue a burst
  a_r10_beats_contig: assert property (@(posedge clk) disable iff (!rst_n)
    (tack && !aack) |-> $past(tack));
endmodule

bind slv_resp_ctrl slv_resp_chk #(
  .DEPTH(WQ_DEPTH), .CW($clog2(WQ_DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .aack(aack), .tack(tack), .retry(retry),
  .dn_req(dn_req), .ev_push(ev_push), .wq_full(wq_full), .wq_count(wq_count)
);

// File: tb/tb_slv_resp_ctrl.sv
`timescale 1ns/1ps
module tb_slv_resp_ctrl;
  localparam int AW = 32, DW = 32, BEATS = 4, DEPTH = 4;
  localparam int DATA_W = BEATS * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ts_valid = 0, ts_burst = 0, dn_done = 0, dn_fail = 0, wq_pop = 0;
  logic [4:0] ts_type = '0;
  logic [AW-1:0] ts_addr = '0;
  logic [2:0] ts_size = '0;
  logic [DATA_W-1:0] ts_wdata = '0;
  logic aack, tack, retry, dn_req, dn_write, dn_burst, wq_valid, wq_burst;
  logic [AW-1:0] dn_addr, wq_addr;
  logic [2:0] wq_size;
  logic [DATA_W-1:0] wq_data;

  int n_chk = 0, n_err = 0;
  bit drain_en = 0;

  logic [AW-1:0]     q_addr[$];
  logic              q_burst[$];
  logic [DATA_W-1:0] q_data[$];

  int o_aack_at, o_aack_n, o_tack_first, o_tack_last, o_tack_n;
  int o_retry_n, o_retry_late, o_dnreq_first, o_resp_at;

  always #4 clk = ~clk;

  slv_resp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_type(ts_type),
    .ts_addr(ts_addr), .ts_burst(ts_burst), .ts_size(ts_size),
    .ts_wdata(ts_wdata), .aack(aack), .tack(tack), .retry(retry),
    .dn_req(dn_req), .dn_addr(dn_addr), .dn_write(dn_write),
    .dn_burst(dn_burst), .dn_done(dn_done), .dn_fail(dn_fail),
    .wq_pop(wq_pop), .wq_valid(wq_valid), .wq_addr(wq_addr),
    .wq_size(wq_size), .wq_burst(wq_burst), .wq_data(wq_data)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 unclaimed, 1 address-only, 2 write, 3 read
  function automatic int b_class(input logic [4:0] t);
    if (t inside {5'h00, 5'h04, 5'h08, 5'h0C, 5'h10}) return 1;
    if (t inside {5'h02, 5'h06}) return 2;
    if (t inside {5'h0A, 5'h0E}) return 3;
    return 0;
  endfunction

  function automatic int b_window(input logic [AW-1:0] a);
    if (a[31:24] == 8'h80) return 0;
    if (a[31:16] == 16'hC000) return 1;
    return -1;
  endfunction

  // R11: compare queue head with the model front and consume it
  task automatic pop_check();
    if (!wq_valid) return;
    if (q_addr.size() == 0) begin
      chk("R11", "model empty at pop", 1, 0);
      return;
    end
    chk("R11", "head addr", wq_addr, q_addr[0]);
    chk("R11", "head burst", wq_burst, q_burst[0]);
    n_chk++;
    if (wq_data != q_data[0]) begin
      n_err++;
      $display("FAIL R11 head data: actual %h expected %h", wq_data, q_data[0]);
    end
    void'(q_addr.pop_front()); void'(q_burst.pop_front()); void'(q_data.pop_front());
  endtask

  always @(negedge clk) begin
    if (drain_en) begin
      wq_pop = ($urandom_range(0, 2) == 0);
      if (wq_pop) pop_check();
    end
  end

  task automatic run_txn(input logic [4:0] t, input logic [AW-1:0] a, input bit b,
                         input logic [DATA_W-1:0] d, input int dly, input bit fail,
                         input int pop_at, input int n_samp, input bit exp_post);
    int dcnt = 0;
    bit responded = 0;
    o_aack_at = -1; o_aack_n = 0; o_tack_first = -1; o_tack_last = -1; o_tack_n = 0;
    o_retry_n = 0; o_retry_late = 0; o_dnreq_first = -1; o_resp_at = -1;
    @(negedge clk);
    ts_valid = 1; ts_type = t; ts_addr = a; ts_burst = b; ts_wdata = d;
    ts_size = b ? 3'd0 : 3'd3;
    @(negedge clk);
    ts_valid = 0;
    for (int i = 1; i <= n_samp; i++) begin
      if (i > 1) @(negedge clk);
      dn_done = 0; dn_fail = 0;
      if (pop_at > 0 && i == pop_at + 1) wq_pop = 0;
      if (aack) begin
        if (o_aack_at < 0) o_aack_at = i;
        o_aack_n++;
        if (exp_post) begin
          q_addr.push_back(a); q_burst.push_back(b); q_data.push_back(d);
          n_chk++;
          if (q_addr.size() > DEPTH) begin
            n_err++;
            $display("FAIL R6 occupancy: actual %0d expected <= %0d", q_addr.size(), DEPTH);
          end
        end
      end
      if (tack) begin
        if (o_tack_first < 0) o_tack_first = i;
        o_tack_last = i;
        o_tack_n++;
      end
      if (retry) begin
        o_retry_n++;
        if (o_tack_first >= 0 && o_tack_first < i) o_retry_late++;
      end
      if (dn_req) begin
        if (o_dnreq_first < 0) o_dnreq_first = i;
        if (!responded) begin
          if (dcnt == dly) begin
            if (fail) dn_fail = 1; else dn_done = 1;
            responded = 1;
            o_resp_at = i;
          end
          dcnt++;
        end
      end
      if (pop_at > 0 && i == pop_at) begin
        pop_check();
        wq_pop = 1;
      end
    end
    dn_done = 0; dn_fail = 0;
  endtask

  task automatic do_txn(input logic [4:0] t, input logic [AW-1:0] a, input bit b,
                        input int dly, input bit fail);
    int c = b_class(t);
    int w = b_window(a);
    int qs = q_addr.size();
    bit post = (c == 2) && (w >= 0) && (b || (w == 0));
    bit comp = (c >= 2) && (w >= 0) && !post;
    logic [DATA_W-1:0] d = {$urandom, $urandom, $urandom, $urandom};
    run_txn(t, a, b, d, dly, fail, 0, 12 + dly + BEATS, post);
    chk("R9", "retry after tack", o_retry_late, 0);
    if (c == 1 && w >= 0) begin
      chk("R2", "aonly aack cycle", o_aack_at, 2);
      chk("R2", "aonly aack count", o_aack_n, 1);
      chk("R2", "aonly tack/retry", o_tack_n + o_retry_n, 0);
    end else if (post) begin
      if (qs < DEPTH) chk("R4", "posted aack cycle", o_aack_at, 2);
      chk("R4", "posted aack count", o_aack_n, 1);
      chk("R10", "posted tack count", o_tack_n, b ? BEATS : 1);
      chk("R10", "tack starts at aack", o_tack_first, o_aack_at);
      chk("R10", "tack contiguous", o_tack_last - o_tack_first + 1, o_tack_n);
      chk("R5", "posted no dn_req", o_dnreq_first, -1);
      chk("R4", "posted no retry", o_retry_n, 0);
    end else if (comp) begin
      chk("R7", "dn_req cycle", o_dnreq_first, 2);
      chk("R8", "aack after response", o_aack_at, o_resp_at + 1);
      chk("R8", "aack count", o_aack_n, 1);
      if (fail) begin
        chk("R8", "fail retry", o_retry_n, 1);
        chk("R8", "fail no tack", o_tack_n, 0);
      end else begin
        chk("R8", "done no retry", o_retry_n, 0);
        chk("R10", "done tack count", o_tack_n, b ? BEATS : 1);
        chk("R10", "tack starts at aack", o_tack_first, o_aack_at);
      end
    end else begin
      // R1 unclaimed codes, R2 address-only miss, R3 read/write miss
      chk(c == 1 ? "R2" : "R3", "silent aack", o_aack_n, 0);
      chk("R3", "silent tack/retry", o_tack_n + o_retry_n, 0);
      chk("R3", "silent dn_req", o_dnreq_first, -1);
    end
  endtask

  function automatic logic [AW-1:0] pick_addr(input int sel);
    case (sel)
      0: return 32'h8000_0000 | ($urandom & 32'h00FF_FFF8);
      1: return 32'hC000_0000 | ($urandom & 32'h0000_FFF8);
      default: return 32'h4000_0000 | ($urandom & 32'h00FF_FFF8);
    endcase
  endfunction

  function automatic logic [4:0] pick_type(input int k);
    case (k)
      0: return 5'h00; 1: return 5'h04; 2: return 5'h08; 3: return 5'h0C;
      4: return 5'h10; 5: return 5'h02; 6: return 5'h06; 7: return 5'h0A;
      8: return 5'h0E; 9: return 5'h01; 10: return 5'h1F;
      default: return 5'h16;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2", "reset outputs", {aack, tack, retry, dn_req, wq_valid}, 0);

    // R1/R2 every address-only code, hit and miss
    for (int k = 0; k < 5; k++) do_txn(pick_type(k), 32'h8000_1000, 0, 0, 0);
    do_txn(5'h08, 32'h1234_0000, 0, 0, 0);
    // R1/R3 unclaimed codes and window misses
    do_txn(5'h01, 32'h8000_0040, 0, 0, 0);
    do_txn(5'h1F, 32'hC000_0040, 1, 0, 0);
    do_txn(5'h02, 32'h4000_0000, 0, 0, 0);
    do_txn(5'h0A, 32'hC001_0000, 0, 0, 0);
    // R4 posted single and burst in the posting window
    do_txn(5'h02, 32'h8000_0100, 0, 0, 0);
    do_txn(5'h06, 32'h8000_0200, 1, 0, 0);
    // R5 burst write into compelled window is posted
    do_txn(5'h02, 32'hC000_0300, 1, 0, 0);
    // R7/R8 compelled single write, success then failure
    do_txn(5'h02, 32'hC000_0400, 0, 3, 0);
    do_txn(5'h06, 32'hC000_0500, 0, 1, 1);
    // R8/R10 reads: burst success, burst failure, single zero delay
    do_txn(5'h0A, 32'h8000_0600, 1, 2, 0);
    do_txn(5'h0E, 32'hC000_0700, 1, 0, 1);
    do_txn(5'h0A, 32'hC000_0800, 0, 0, 0);

    // R6 fill the queue, stall a fifth posted burst, release with one pop
    for (int k = 0; k < DEPTH - 3; k++) do_txn(5'h02, 32'h8000_1000 + k * 32, 1, 0, 0);
    chk("R6", "queue filled", q_addr.size(), DEPTH);
    begin
      logic [DATA_W-1:0] d = {$urandom, $urandom, $urandom, $urandom};
      run_txn(5'h02, 32'hC000_2000, 1, d, 0, 0, 12, 22, 1);
      chk("R6", "stalled aack cycle", o_aack_at, 14);
      chk("R6", "stalled aack count", o_aack_n, 1);
      chk("R10", "stalled burst tacks", o_tack_n, BEATS);
    end

    // random traffic with random draining
    drain_en = 1;
    for (int n = 0; n < 80; n++) begin
      do_txn(pick_type($urandom_range(0, 11)), pick_addr($urandom_range(0, 2)),
             $urandom_range(0, 1) == 1, $urandom_range(0, 5), $urandom_range(0, 3) == 0);
    end
    repeat (60) @(negedge clk);
    drain_en = 0;
    @(negedge clk);
    wq_pop = 0;
    chk("R11", "queue drained (model)", q_addr.size(), 0);
    chk("R11", "queue drained (port)", wq_valid, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule